// File: doc/BRIEF.md
# Field-Rate Vertical Line Counter with Composite Sync

This block counts video lines in the system clock domain. It advances only when a one-cycle line strobe arrives from the horizontal timing logic. Each field is `LINES_PER_FIELD` lines long (262 by default), so the block divides the line rate down to a field-rate vertical reset strobe. With a 15,731 Hz line strobe, that strobe repeats at about 60.04 Hz.

The last line of the field is found by a sparse decode. The counter tests only the bits that are set in the terminal value (bits 8, 2 and 0 for 261), much as a gate-minimal discrete design would do. The decode is active low internally. It is safe because no reachable count below the terminal value has all of those bits set.

After each wrap, a vertical sync level is held for `VS_LINES` lines (3 by default). It is mixed with the incoming horizontal sync level by exclusive-OR, and the result is inverted to give an active-low composite sync.

Top module: `vcnt_field_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears after that edge to `line_count` = 0, `vreset` = 0 and `vsync` = 0.
- R2: On a clock edge where `line_stb` is 0, `line_count` keeps its value.
- R3: On a clock edge where `line_stb` is 1 and `line_count` is not 261, `line_count` increases by exactly 1 after that edge.
- R4: On a clock edge where `line_stb` is 1 and `line_count` is 261 (binary 1_0000_0101, bits 8, 2 and 0 set), `line_count` becomes 0. `line_count` never exceeds 261.
- R5: `vreset` is high for exactly the one clock cycle that follows the wrapping edge of R4, and is low at all other times. Consecutive `vreset` pulses are separated by exactly 262 line strobes.
- R6: `vsync` goes high on the wrapping edge. It stays high until the strobe edge that takes `line_count` to `VS_LINES` (3), and is then low. After reset it stays low until the first wrap.
- R7: `csync_n` equals NOT(`hsync` XOR `vsync`) in the same cycle, with no register in the path from `hsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_stb | input | 1 | One-cycle strobe at the end of each line; acts as the count enable |
| hsync | input | 1 | Horizontal sync level, active high |
| line_count | output | 9 | Current line number, 0 to 261 |
| vreset | output | 1 | One-cycle strobe after the field wraps |
| vsync | output | 1 | Vertical sync level, active high |
| csync_n | output | 1 | Inverted XOR of horizontal and vertical sync |

## Verification
`line_count`, `vreset` and `vsync` are registered. Each one is due in the cycle after the rising edge that sampled `line_stb`. `csync_n` follows `hsync` in the same cycle. The bench drives its inputs just after a falling edge and updates its behavioural model at the rising edge from the same inputs. It compares all four outputs at the next falling edge, so a registered result is checked one edge after its cause, and `csync_n` is checked against the `hsync` value currently applied. Strobe spacing is varied (every cycle, every fifth cycle, every second cycle, and long idle stretches), and a reset is applied mid-field. These cover the hold, increment, wrap and strobe-spacing cases, and every `vreset` pulse is checked against a count of 262 strobes.

// File: rtl/vcnt_pkg.sv
// Package vcnt_pkg
// Shared helper for the vertical line counter. It provides the sparse
// terminal-count test. Assumes the terminal value fits in 32 bits.
package vcnt_pkg;

    // True when every bit set in the mask is also set in the value.
    function automatic logic bits_present(input logic [31:0] value,
                                          input logic [31:0] mask);
        return &(value | ~mask);
    endfunction

endpackage

// File: rtl/vcnt_line_counter.sv
// Module vcnt_line_counter
// Counts line strobes from 0 to TERM and wraps to zero on the strobe that
// follows TERM. The last line is detected from only the bits that are set in
// TERM (active-low internally). Assumes no value below TERM holds all of
// those bits, which is true for any TERM.
module vcnt_line_counter #(
    parameter int CNT_W = 9,
    parameter int TERM  = 261
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    import vcnt_pkg::*;

    localparam logic [CNT_W-1:0] TERM_V = CNT_W'(TERM);

    logic [CNT_W-1:0] count_q;
    logic             last_n;

    // Sparse, active-low decode of the last line in the field.
    always_comb begin
        last_n = ~bits_present(32'(count_q), 32'(TERM_V));
    end

    // Advance on each strobe; return to zero on the strobe after the last line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (line_stb) begin
            if (!last_n) count_q <= '0;
            else         count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
    assign wrap  = line_stb & ~last_n;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= TERM_V); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> $stable(count_q)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && count_q != TERM_V) |=> count_q == $past(count_q) + 1'b1); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && count_q == TERM_V) |=> count_q == '0); // R4

endmodule

// File: rtl/vcnt_vsync_gen.sv
// Module vcnt_vsync_gen
// Registers the field strobe and the vertical sync level. Sync rises on the
// wrapping edge and falls on the strobe edge that takes the count to
// VS_LINES. Assumes 1 <= VS_LINES <= TERM.
module vcnt_vsync_gen #(
    parameter int CNT_W    = 9,
    parameter int VS_LINES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    output logic             vreset,
    output logic             vsync
);
    localparam logic [CNT_W-1:0] VS_END = CNT_W'(VS_LINES);

    logic vr_q;
    logic vs_q;
    logic [CNT_W-1:0] next_count;

    // Count value that the counter loads on this strobe when it does not wrap.
    always_comb begin
        next_count = count + 1'b1;
    end

    // Field strobe: high for the single cycle after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) vr_q <= 1'b0;
        else        vr_q <= wrap;
    end

    // Sync level: set by a wrap, cleared once the count reaches VS_END.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q <= 1'b0;
        end else if (wrap) begin
            vs_q <= 1'b1;
        end else if (line_stb && next_count >= VS_END) begin
            vs_q <= 1'b0;
        end
    end

    assign vreset = vr_q;
    assign vsync  = vs_q;

    AST_VRESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vr_q |=> !vr_q); // R5
    AST_VRESET_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vr_q |-> (count == '0)); // R5
    AST_VSYNC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vs_q |-> (count < VS_END)); // R6

endmodule

// File: rtl/vcnt_csync_mix.sv
// Module vcnt_csync_mix
// Combines the horizontal and vertical sync levels by exclusive-OR and
// inverts the result. Purely combinational; assumes both inputs are clean
// levels in the system clock domain.
module vcnt_csync_mix (
    input  logic hsync,
    input  logic vsync,
    output logic csync_n
);
    // Inverted XOR mix of the two sync levels.
    always_comb begin
        csync_n = ~(hsync ^ vsync);
    end

    AST_CSYNC_MIX: assert final (csync_n === ~(hsync ^ vsync)); // R7

endmodule

// File: rtl/vcnt_field_timer.sv
// Module vcnt_field_timer
// Top level of the vertical line counter. Counts line strobes, issues a
// field-rate reset strobe, generates vertical sync and the inverted composite
// sync. Assumes line_stb is a one-cycle pulse synchronous to clk.
module vcnt_field_timer #(
    parameter  int LINES_PER_FIELD = 262,
    parameter  int VS_LINES        = 3,
    localparam int CNT_W           = $clog2(LINES_PER_FIELD),
    localparam int TERM            = LINES_PER_FIELD - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             hsync,
    output logic [CNT_W-1:0] line_count,
    output logic             vreset,
    output logic             vsync,
    output logic             csync_n
);
    logic wrap;

    vcnt_line_counter #(
        .CNT_W (CNT_W),
        .TERM  (TERM)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .count    (line_count),
        .wrap     (wrap)
    );

    vcnt_vsync_gen #(
        .CNT_W    (CNT_W),
        .VS_LINES (VS_LINES)
    ) u_vsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_stb (line_stb),
        .wrap     (wrap),
        .count    (line_count),
        .vreset   (vreset),
        .vsync    (vsync)
    );

    vcnt_csync_mix u_mix (
        .hsync   (hsync),
        .vsync   (vsync),
        .csync_n (csync_n)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (line_count == '0 && !vreset && !vsync)); // R1

endmodule

// File: tb/vcnt_field_timer_test.sv
// Bench for vcnt_field_timer: a behavioural line model is updated on every
// rising edge and compared with the outputs on every falling edge.
module vcnt_field_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 262;
    localparam int VSL        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_stb = 1'b0;
    logic       hsync = 1'b0;
    logic [8:0] line_count;
    logic       vreset, vsync, csync_n;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // behavioural model state
    int m_cnt = 0;
    bit m_vr  = 0;
    bit m_vs  = 0;
    int stb_since_vr = 0;
    logic [15:0] lfsr = 16'hACE1;

    vcnt_field_timer #(.LINES_PER_FIELD(LINES), .VS_LINES(VSL)) uut (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .hsync(hsync),
        .line_count(line_count), .vreset(vreset), .vsync(vsync), .csync_n(csync_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model update from the inputs present at the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_vr = 0; m_vs = 0; stb_since_vr = 0;
        end else begin
            m_vr = 0;
            if (line_stb) begin
                stb_since_vr++;
                if (m_cnt == LINES - 1) begin
                    m_cnt = 0; m_vr = 1; m_vs = 1;
                end else begin
                    m_cnt++;
                    if (m_cnt >= VSL) m_vs = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model; then check the strobe spacing.
    task automatic compare_all(input bit in_reset);
        string t;
        t = in_reset ? "R1 count" : (m_vr ? "R4 count wrap" : "R3/R2 count");
        chk(line_count == 9'(m_cnt), t, int'(line_count), m_cnt);
        chk(line_count <= 9'd261, "R4 never above 261", int'(line_count), 261);
        chk(vreset == m_vr, in_reset ? "R1 vreset" : "R5 vreset", int'(vreset), int'(m_vr));
        chk(vsync == m_vs, in_reset ? "R1 vsync" : "R6 vsync", int'(vsync), int'(m_vs));
        chk(csync_n == !(hsync ^ m_vs), "R7 csync_n", int'(csync_n), int'(!(hsync ^ m_vs)));
        if (vreset) begin
            chk(stb_since_vr == LINES, "R5 strobes per field", stb_since_vr, LINES);
            stb_since_vr = 0;
        end
    endtask

    // One cycle: check at the falling edge, then apply new inputs.
    task automatic step(input bit rst_v, input bit stb_v);
        @(negedge clk);
        compare_all(!rst_n);
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hsync = lfsr[0];
        rst_n = rst_v;
        line_stb = stb_v;
        #1;
        chk(csync_n == !(hsync ^ m_vs), "R7 csync_n same cycle", int'(csync_n),
            int'(!(hsync ^ m_vs)));
    endtask

    initial begin
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0);          // R1 reset
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1);        // strobe every cycle
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0);         // R2 idle hold
        for (int i = 0; i < 2800; i++) step(1'b1, (i % 5) == 0); // sparse strobes
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);          // R1 mid-field reset
        for (int i = 0; i < 1200; i++) step(1'b1, (i % 2) == 0);
        for (int i = 0; i < 600; i++) step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule